// File: doc/BRIEF.md
# Multi-Mode Operand Address Resolver

This block turns a decoded operand specifier into an operand value and an effective address. A specifier carries a 4-bit mode code, a register number and a short address/offset field. After a one-cycle start strobe the unit captures the specifier and reads the named register through a combinational read port. It picks one of eleven ways of locating the operand and issues as many memory reads as that way needs: none, one, or two. For the two auto-stepping modes it writes the updated base register back.

The unit serves an execution pipeline stage that has already decoded the opcode. Memory is reached through a request/valid handshake: the unit raises a request with an address and holds both until the memory answers with valid and the data word in the same cycle. The end of every operation is marked by a one-cycle done pulse. The effective address, operand and illegal flag stay unchanged from that pulse until the next accepted start. All address arithmetic wraps modulo the address width.

Top module: `eff_addr_unit`

## Requirements
- R1: While reset is high and in the cycles after it, busy, done, mem_req, rf_we and illegal are low, and eff_addr and operand are zero.
- R2: Mode code 0 (implied) returns the accumulator input as operand, reports eff_addr 0 and issues no memory read.
- R3: Mode code 1 (immediate) returns the field, zero-extended, as operand with eff_addr 0 and no memory read.
- R4: Mode code 2 (register) returns the named register's contents as operand with eff_addr 0 and no memory read.
- R5: Mode code 3 (register indirect) uses the named register's contents as eff_addr, and mode code 4 (direct) uses the zero-extended field. Each makes exactly one read, and the operand is the word returned.
- R6: Mode code 5 (indirect) first reads memory at the zero-extended field, then uses the returned word as eff_addr for a second read that supplies the operand. That is two reads in total.
- R7: Mode code 6 (indexed) forms eff_addr as zero-extended field plus the index input. Mode code 7 (base) forms it as named register plus zero-extended field. Each makes one read and wraps modulo 2^ADDR_W.
- R8: Mode code 8 (relative) forms eff_addr as the pc input plus the sign-extended field (field MSB is the sign), modulo 2^ADDR_W, with one read.
- R9: Mode code 9 (auto-increment) reads at the register's current value. In the cycle done is high, it drives rf_we with rf_waddr equal to the register number and rf_wdata equal to the old value plus one.
- R10: Mode code 10 (auto-decrement) uses the register's value minus one as eff_addr for its single read, and writes that decremented value back in the cycle done is high.
- R11: Mode codes 11 to 15 finish with done and illegal high, eff_addr and operand zero, no memory read and no register write.
- R12: mem_req stays high with mem_addr unchanged until mem_valid is high. A read completes in the cycle mem_valid is high, so with a response delay of L cycles each read costs L+1 cycles. Done appears 2 + reads·(L+1) cycles after the start cycle.
- R13: done lasts one cycle. A start while busy is ignored. eff_addr, operand and illegal hold their values while idle until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a specifier when idle |
| mode | input | 4 | Location mode code |
| reg_sel | input | $clog2(NUM_REGS) | Register number |
| field | input | FIELD_W | Address/offset field |
| acc | input | ADDR_W | Accumulator value for implied mode |
| pc | input | ADDR_W | Program counter value |
| index_val | input | ADDR_W | Index register value |
| rf_raddr | output | $clog2(NUM_REGS) | Register file read address |
| rf_rdata | input | ADDR_W | Register file read data (combinational) |
| rf_we | output | 1 | Register write-back strobe |
| rf_waddr | output | $clog2(NUM_REGS) | Write-back register number |
| rf_wdata | output | ADDR_W | Write-back value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_valid | input | 1 | Memory response valid |
| mem_rdata | input | ADDR_W | Memory read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last mode code was unassigned |
| eff_addr | output | ADDR_W | Effective address |
| operand | output | ADDR_W | Operand value |

## Verification
The bench builds the unit with an 8-bit address, a 6-bit field and four registers. This makes a complete sweep of every mode code, every register number and every field value practical: 4096 operations. The negative half of the field range reaches the sign extension of relative mode. The 8-bit width makes carries past the top bit frequent, so wrap-around in indexed, base, relative and auto-stepping arithmetic is exercised. The register file is seeded with 0x00 and 0xFF so that stepping across both ends occurs early. The memory response delay cycles through 0, 1 and 2, which checks the exact completion cycle of one- and two-read modes.

// File: rtl/eau_pkg.sv
package eau_pkg;

    localparam logic [3:0] MODE_IMPLIED  = 4'd0;
    localparam logic [3:0] MODE_IMMED    = 4'd1;
    localparam logic [3:0] MODE_REG      = 4'd2;
    localparam logic [3:0] MODE_REGIND   = 4'd3;
    localparam logic [3:0] MODE_DIRECT   = 4'd4;
    localparam logic [3:0] MODE_INDIRECT = 4'd5;
    localparam logic [3:0] MODE_INDEXED  = 4'd6;
    localparam logic [3:0] MODE_BASE     = 4'd7;
    localparam logic [3:0] MODE_RELATIVE = 4'd8;
    localparam logic [3:0] MODE_AUTOINC  = 4'd9;
    localparam logic [3:0] MODE_AUTODEC  = 4'd10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_READ1,
        ST_READ2
    } seq_state_e;

    // What a mode code asks of the sequencer
    typedef struct packed {
        logic       legal;
        logic [1:0] reads;
        logic       use_acc;
        logic       use_field;
        logic       writeback;
    } mode_plan_t;

    function automatic mode_plan_t plan_for(input logic [3:0] m);
        mode_plan_t p;
        p       = '0;
        p.legal = 1'b1;
        case (m)
            MODE_IMPLIED:  p.use_acc   = 1'b1;
            MODE_IMMED:    p.use_field = 1'b1;
            MODE_REG:      p.reads     = 2'd0;
            MODE_INDIRECT: p.reads     = 2'd2;
            MODE_AUTOINC, MODE_AUTODEC: begin
                p.reads     = 2'd1;
                p.writeback = 1'b1;
            end
            MODE_REGIND, MODE_DIRECT, MODE_INDEXED,
            MODE_BASE, MODE_RELATIVE: p.reads = 2'd1;
            default:       p.legal     = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/eau_addr_gen.sv
module eau_addr_gen
    import eau_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int FIELD_W = 8
) (
    input  logic [3:0]         mode,
    input  logic [FIELD_W-1:0] field,
    input  logic [ADDR_W-1:0]  reg_val,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [ADDR_W-1:0]  index_val,
    output logic [ADDR_W-1:0]  field_ext,
    output logic [ADDR_W-1:0]  ea,
    output logic [ADDR_W-1:0]  wb_val
);

    localparam int EXT_W = ADDR_W - FIELD_W;
    localparam logic [ADDR_W-1:0] WORD_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] field_sx;
    logic [ADDR_W-1:0] reg_inc;
    logic [ADDR_W-1:0] reg_dec;

    assign field_ext = {{EXT_W{1'b0}}, field};
    assign field_sx  = {{EXT_W{field[FIELD_W-1]}}, field};
    assign reg_inc   = reg_val + WORD_STEP;
    assign reg_dec   = reg_val - WORD_STEP;

    always_comb begin
        ea     = '0;
        wb_val = reg_val;
        case (mode)
            MODE_REGIND:   ea = reg_val;
            MODE_DIRECT,
            MODE_INDIRECT: ea = field_ext;
            MODE_INDEXED:  ea = field_ext + index_val;
            MODE_BASE:     ea = reg_val + field_ext;
            MODE_RELATIVE: ea = pc + field_sx;
            MODE_AUTOINC: begin
                ea     = reg_val;
                wb_val = reg_inc;
            end
            MODE_AUTODEC: begin
                ea     = reg_dec;
                wb_val = reg_dec;
            end
            default:       ea = '0;
        endcase
    end

endmodule

// File: rtl/eau_seq.sv
module eau_seq
    import eau_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int FIELD_W = 8,
    parameter int REG_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [3:0]         mode_in,
    input  logic [REG_W-1:0]   reg_in,
    input  logic [FIELD_W-1:0] field_in,
    output logic [3:0]         mode_q,
    output logic [REG_W-1:0]   reg_q,
    output logic [FIELD_W-1:0] field_q,
    input  logic [ADDR_W-1:0]  reg_val,
    input  logic [ADDR_W-1:0]  acc,
    input  logic [ADDR_W-1:0]  field_ext,
    input  logic [ADDR_W-1:0]  ea_calc,
    input  logic [ADDR_W-1:0]  wb_calc,
    input  logic               mem_valid,
    input  logic [ADDR_W-1:0]  mem_rdata,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               rf_we,
    output logic [ADDR_W-1:0]  rf_wdata,
    output logic               done,
    output logic               busy,
    output logic               illegal,
    output logic [ADDR_W-1:0]  eff_addr,
    output logic [ADDR_W-1:0]  operand
);

    seq_state_e state;
    mode_plan_t plan;

    assign plan = plan_for(mode_q);
    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mode_q   <= '0;
            reg_q    <= '0;
            field_q  <= '0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            rf_we    <= 1'b0;
            rf_wdata <= '0;
            done     <= 1'b0;
            illegal  <= 1'b0;
            eff_addr <= '0;
            operand  <= '0;
        end else begin
            done  <= 1'b0;
            rf_we <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= mode_in;
                        reg_q   <= reg_in;
                        field_q <= field_in;
                        illegal <= 1'b0;
                        state   <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    if (!plan.legal) begin
                        illegal  <= 1'b1;
                        eff_addr <= '0;
                        operand  <= '0;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (plan.reads == 2'd0) begin
                        eff_addr <= '0;
                        if (plan.use_acc) begin
                            operand <= acc;
                        end else if (plan.use_field) begin
                            operand <= field_ext;
                        end else begin
                            operand <= reg_val;
                        end
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        eff_addr <= ea_calc;
                        mem_addr <= ea_calc;
                        mem_req  <= 1'b1;
                        rf_wdata <= wb_calc;
                        state    <= ST_READ1;
                    end
                end
                ST_READ1: begin
                    if (mem_valid) begin
                        if (plan.reads == 2'd2) begin
                            eff_addr <= mem_rdata;
                            mem_addr <= mem_rdata;
                            state    <= ST_READ2;
                        end else begin
                            mem_req <= 1'b0;
                            operand <= mem_rdata;
                            rf_we   <= plan.writeback;
                            done    <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                end
                ST_READ2: begin
                    if (mem_valid) begin
                        mem_req <= 1'b0;
                        operand <= mem_rdata;
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
    parameter int ADDR_W   = 16,
    parameter int FIELD_W  = 8,
    parameter int NUM_REGS = 8,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [3:0]         mode,
    input  logic [REG_W-1:0]   reg_sel,
    input  logic [FIELD_W-1:0] field,
    input  logic [ADDR_W-1:0]  acc,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [ADDR_W-1:0]  index_val,
    output logic [REG_W-1:0]   rf_raddr,
    input  logic [ADDR_W-1:0]  rf_rdata,
    output logic               rf_we,
    output logic [REG_W-1:0]   rf_waddr,
    output logic [ADDR_W-1:0]  rf_wdata,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_valid,
    input  logic [ADDR_W-1:0]  mem_rdata,
    output logic               busy,
    output logic               done,
    output logic               illegal,
    output logic [ADDR_W-1:0]  eff_addr,
    output logic [ADDR_W-1:0]  operand
);

    logic [3:0]         mode_q;
    logic [REG_W-1:0]   reg_q;
    logic [FIELD_W-1:0] field_q;
    logic [ADDR_W-1:0]  field_ext;
    logic [ADDR_W-1:0]  ea_calc;
    logic [ADDR_W-1:0]  wb_calc;

    assign rf_raddr = reg_q;
    assign rf_waddr = reg_q;

    eau_addr_gen #(
        .ADDR_W  (ADDR_W),
        .FIELD_W (FIELD_W)
    ) u_addr_gen (
        .mode      (mode_q),
        .field     (field_q),
        .reg_val   (rf_rdata),
        .pc        (pc),
        .index_val (index_val),
        .field_ext (field_ext),
        .ea        (ea_calc),
        .wb_val    (wb_calc)
    );

    eau_seq #(
        .ADDR_W  (ADDR_W),
        .FIELD_W (FIELD_W),
        .REG_W   (REG_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode_in   (mode),
        .reg_in    (reg_sel),
        .field_in  (field),
        .mode_q    (mode_q),
        .reg_q     (reg_q),
        .field_q   (field_q),
        .reg_val   (rf_rdata),
        .acc       (acc),
        .field_ext (field_ext),
        .ea_calc   (ea_calc),
        .wb_calc   (wb_calc),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .rf_we     (rf_we),
        .rf_wdata  (rf_wdata),
        .done      (done),
        .busy      (busy),
        .illegal   (illegal),
        .eff_addr  (eff_addr),
        .operand   (operand)
    );

endmodule

// File: rtl/eau_checker.sv
module eau_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              rf_we,
    input logic              mem_req,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              illegal,
    input logic [ADDR_W-1:0] eff_addr,
    input logic [ADDR_W-1:0] operand
);

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9 R10
    writeback_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> done);

    // R12
    request_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(eff_addr) && $stable(operand) && $stable(illegal)));

    // R11
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!mem_req && !rf_we));

    // R12
    request_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

endmodule

bind eff_addr_unit eau_checker #(.ADDR_W(ADDR_W)) u_eau_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .rf_we     (rf_we),
    .mem_req   (mem_req),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .illegal   (illegal),
    .eff_addr  (eff_addr),
    .operand   (operand)
);

// File: tb/test_eff_addr_unit.sv
module test_eff_addr_unit;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int FW = 6;
    localparam int NR = 4;
    localparam int RW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [3:0]    mode;
    logic [RW-1:0] reg_sel;
    logic [FW-1:0] field;
    logic [AW-1:0] acc, pc, index_val;
    logic [RW-1:0] rf_raddr, rf_waddr;
    logic [AW-1:0] rf_rdata, rf_wdata;
    logic          rf_we;
    logic          mem_req, mem_valid;
    logic [AW-1:0] mem_addr, mem_rdata;
    logic          busy, done, illegal;
    logic [AW-1:0] eff_addr, operand;

    logic [AW-1:0] regs [NR];
    logic [1:0]    lat;
    logic [7:0]    cnt;
    int            rd_count;
    int            nchk = 0;
    int            nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eff_addr_unit #(.ADDR_W(AW), .FIELD_W(FW), .NUM_REGS(NR)) i_eff_addr_unit (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .reg_sel(reg_sel),
        .field(field), .acc(acc), .pc(pc), .index_val(index_val),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .illegal(illegal), .eff_addr(eff_addr),
        .operand(operand)
    );

    function automatic logic [AW-1:0] mem_word(input logic [AW-1:0] a);
        return a * 8'd37 + 8'h5B;
    endfunction

    assign rf_rdata  = regs[rf_raddr];
    assign mem_rdata = mem_word(mem_addr);
    assign mem_valid = mem_req && (cnt >= {6'd0, lat});

    always @(posedge clk) begin
        if (rst) begin
            regs[0]  <= 8'h00;
            regs[1]  <= 8'hFF;
            regs[2]  <= 8'h80;
            regs[3]  <= 8'h3C;
            cnt      <= 8'd0;
            rd_count <= 0;
        end else begin
            if (rf_we) regs[rf_waddr] <= rf_wdata;
            if (mem_req && mem_valid) begin
                cnt      <= 8'd0;
                rd_count <= rd_count + 1;
            end else if (mem_req) begin
                cnt <= cnt + 8'd1;
            end else begin
                cnt <= 8'd0;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] m, input logic [RW-1:0] r,
                          input logic [FW-1:0] f, input int id);
        logic [AW-1:0] rv, fz, fs, e_ea, e_op, e_wb;
        int            e_reads, waited, base;
        logic          e_we, e_ill;
        string         tag;
        pc        = 8'(id * 13 + 7);
        index_val = 8'(id * 29 + 3);
        acc       = 8'(id * 7 + 1);
        lat       = 2'(id % 3);
        rv = regs[r];
        fz = {2'b00, f};
        fs = {{2{f[FW-1]}}, f};
        e_ea = 8'd0; e_op = 8'd0; e_wb = 8'd0;
        e_reads = 0; e_we = 1'b0; e_ill = 1'b0;
        case (m)
            4'd0:  begin tag = "R2"; e_op = acc; end
            4'd1:  begin tag = "R3"; e_op = fz; end
            4'd2:  begin tag = "R4"; e_op = rv; end
            4'd3:  begin tag = "R5"; e_ea = rv; e_reads = 1; end
            4'd4:  begin tag = "R5"; e_ea = fz; e_reads = 1; end
            4'd5:  begin tag = "R6"; e_ea = mem_word(fz); e_reads = 2; end
            4'd6:  begin tag = "R7"; e_ea = fz + index_val; e_reads = 1; end
            4'd7:  begin tag = "R7"; e_ea = rv + fz; e_reads = 1; end
            4'd8:  begin tag = "R8"; e_ea = pc + fs; e_reads = 1; end
            4'd9:  begin tag = "R9"; e_ea = rv; e_reads = 1; e_we = 1'b1; e_wb = rv + 8'd1; end
            4'd10: begin tag = "R10"; e_ea = rv - 8'd1; e_reads = 1; e_we = 1'b1; e_wb = rv - 8'd1; end
            default: begin tag = "R11"; e_ill = 1'b1; end
        endcase
        if (e_reads > 0) e_op = mem_word(e_ea);
        base    = rd_count;
        mode    = m;
        reg_sel = r;
        field   = f;
        start   = 1'b1;
        @(negedge clk);
        // R13: second start cycle with scrambled specifier must be ignored
        mode    = ~m;
        reg_sel = ~r;
        field   = ~f;
        @(negedge clk);
        start  = 1'b0;
        waited = 2;
        while (!done && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        chk(tag, "done", 32'(done), 32'd1);
        chk(tag, "eff_addr", 32'(eff_addr), 32'(e_ea));
        chk(tag, "operand", 32'(operand), 32'(e_op));
        chk(tag, "illegal", 32'(illegal), 32'(e_ill));
        chk(tag, "memory reads", 32'(rd_count - base), 32'(e_reads));
        chk(tag, "rf_we", 32'(rf_we), 32'(e_we));
        if (e_we) begin
            chk(tag, "rf_waddr", 32'(rf_waddr), 32'(r));
            chk(tag, "rf_wdata", 32'(rf_wdata), 32'(e_wb));
        end
        chk("R12", "completion cycle", 32'(waited), 32'(2 + e_reads * (int'(lat) + 1)));
        @(negedge clk);
        chk("R13", "done pulse width", 32'(done), 32'd0);
        chk("R13", "eff_addr held", 32'(eff_addr), 32'(e_ea));
        chk("R13", "operand held", 32'(operand), 32'(e_op));
        chk("R13", "illegal held", 32'(illegal), 32'(e_ill));
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        nfail++;
        $display("FAIL R13 watchdog: actual expired expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int id;
        rst = 1'b1; start = 1'b0; mode = 4'd0; reg_sel = '0; field = '0;
        acc = '0; pc = '0; index_val = '0; lat = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "mem_req", 32'(mem_req), 32'd0);
        chk("R1", "rf_we", 32'(rf_we), 32'd0);
        chk("R1", "illegal", 32'(illegal), 32'd0);
        chk("R1", "eff_addr", 32'(eff_addr), 32'd0);
        chk("R1", "operand", 32'(operand), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy after reset", 32'(busy), 32'd0);
        id = 0;
        for (int m = 0; m < 16; m++) begin
            for (int r = 0; r < NR; r++) begin
                for (int f = 0; f < (1 << FW); f++) begin
                    run_op(4'(m), 2'(r), 6'(f), id);
                    id++;
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule